// File: doc/BRIEF.md
# SPI Register Target with Axis Conversion Readback

This block is the serial front end of a three-axis sensor's register space. An SPI host (clock idle low, data captured on the rising clock edge) opens a transaction by pulling chip select low and sending a command byte, most significant bit first. Bit 7 of the command selects the direction (1 = read, 0 = write). Bits 6..0 select the register index. A write moves one data byte to an external register file through a single-cycle write strobe. A read shifts the addressed byte back to the host over the next eight clocks. The pointer then keeps advancing for as long as chip select stays low.

The axis indices are handled differently. Index 0x00 is X high, 0x02 is Y high and 0x04 is Z high. Reading one of these indices requests an analog-to-digital conversion through a start/done handshake. The block keeps the latest 12-bit result of each axis. It returns that result left-justified across two bytes, with four zero bits in the low positions. The read stream after the axis bytes follows a fixed path through the other axes and then the status and control registers.

All serial inputs are brought into the system clock domain by synchronizers. The data output comes with a separate output-enable, which the pad logic uses to set the line to high impedance.

Top module: `spi_conv_target`

## Requirements
- R1: After reset, `sdo_oe`, `conv_start` and `reg_wr_en` are all low.
- R2: A command with bit 7 = 0 and an index of 0x06 or 0x08..0x0D, followed by one data byte, produces exactly one single-cycle `reg_wr_en` pulse. During that pulse `reg_wr_addr` holds the index and `reg_wr_data` holds the data byte.
- R3: A write command to any other index produces no `reg_wr_en` pulse.
- R4: A command with bit 7 = 1 and an index in 0x08..0x0E returns `reg_rd_data`, read at that index, during the next eight clocks, MSB first.
- R5: A read of an unmapped index (0x06, 0x07, 0x0F..0x7F) returns 0x00.
- R6: A read command at index 0x00, 0x02 or 0x04 raises `conv_start` for one cycle, with `conv_axis` = 0, 1 or 2 respectively (X, Y, Z). Reads at 0x01, 0x03 and 0x05 start no conversion.
- R7: An axis high byte carries result bits 11..4. The axis low byte carries bits 3..0 in bit positions 7..4, and zeros in bits 3..0.
- R8: While chip select stays low, the read pointer advances once per byte. It steps by one through 0x00..0x05, goes from 0x05 to 0x0E, then 0x0D, then 0x0C, and after that returns 0x00 on every further byte. Any other index steps up by one.
- R9: If the first clock of the byte after an axis command comes before `conv_done`, the block returns the previously completed result for that axis and does not stall.
- R10: Raising chip select abandons a partial transaction. A write cut short produces no strobe, and the next transaction takes its first byte as a command.
- R11: `sdo_oe` is high only during the data bytes of a read. It falls within three clock cycles after `cs_n` rises.
- R12: `sdo` changes only while `sclk` is low. Each new bit appears after a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means the pin is high impedance |
| conv_start | output | 1 | One-cycle request for an A/D conversion |
| conv_axis | output | 2 | Axis of the requested conversion (0 = X, 1 = Y, 2 = Z) |
| conv_done | input | 1 | One-cycle pulse when `conv_data` is valid |
| conv_data | input | 12 | Conversion result |
| reg_wr_en | output | 1 | One-cycle write strobe to the register file |
| reg_wr_addr | output | 7 | Register index of the write |
| reg_wr_data | output | 8 | Data of the write |
| reg_rd_addr | output | 7 | Register index currently being read |
| reg_rd_data | input | 8 | Register file contents at `reg_rd_addr` |

## Verification
Any fault in the bit counter or the command decode shows up at the ports within one byte. The host sees a misplaced bit, a missing or extra write strobe, or a `conv_start` on the wrong axis. A wrong step in the pointer sequence corrupts every byte that follows it in a long read, so streams of up to ten bytes are compared byte by byte. A result slot that is updated at the wrong time appears only in the byte after an axis command. For that reason conversion latency is varied both above and below the host's wait. A stuck output-enable is visible two or three cycles after chip select rises.

// File: rtl/spi_conv_pkg.sv
package spi_conv_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = 7;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [IDX_W-1:0] IDX_STAT  = 7'h0E;
  localparam logic [IDX_W-1:0] IDX_CTLB  = 7'h0D;
  localparam logic [IDX_W-1:0] IDX_CTLC  = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_TAIL  = 7'h7F;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;

  function automatic logic idx_writable(input logic [IDX_W-1:0] idx);
    return (idx == 7'h06) || ((idx >= 7'h08) && (idx <= 7'h0D));
  endfunction

  function automatic logic idx_external(input logic [IDX_W-1:0] idx);
    return (idx >= 7'h08) && (idx <= 7'h0E);
  endfunction

  // last_axis_byte is the index of the final axis low byte
  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] last_axis_byte);
    logic [IDX_W-1:0] nxt;
    if (idx == last_axis_byte)  nxt = IDX_STAT;
    else if (idx == IDX_STAT)   nxt = IDX_CTLB;
    else if (idx == IDX_CTLB)   nxt = IDX_CTLC;
    else if (idx == IDX_CTLC)   nxt = IDX_TAIL;
    else if (idx == IDX_TAIL)   nxt = IDX_TAIL;
    else                        nxt = idx + 7'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int             STAGES  = 2,
  parameter int             N       = 3,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar g = 0; g < N; g++) begin : g_chain
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], din[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= chain_d;
    end

    assign dout[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              sclk_rise,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);

  logic              sclk_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign byte_done = cs_act & sclk_rise & (cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_byte   = {sh_q[BYTE_W-2:0], sdi_s};
  assign bit_cnt   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (!cs_act) begin
      cnt_d = '0;
    end else if (sclk_rise) begin
      cnt_d = cnt_q + CNT_W'(1);
      sh_d  = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      cnt_q       <= cnt_d;
      sh_q        <= sh_d;
    end
  end

endmodule

// File: rtl/spi_result_store.sv
module spi_result_store
  import spi_conv_pkg::*;
#(
  parameter int AXES  = 3,
  parameter int RES_W = 12,
  parameter int AX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AX_W-1:0]   wr_axis,
  input  logic [RES_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [BYTE_W-1:0] rd_byte
);

  localparam int PAD_W = 2 * BYTE_W - RES_W;

  logic [RES_W-1:0]    res_q [AXES];
  logic [IDX_W-1:0]    ax_sel;
  logic [RES_W-1:0]    sel_res;
  logic [2*BYTE_W-1:0] padded;

  for (genvar g = 0; g < AXES; g++) begin : g_slot
    logic             slot_we;
    logic [RES_W-1:0] slot_d;

    always_comb begin
      slot_we = wr_en && (wr_axis == AX_W'(g));
      slot_d  = slot_we ? wr_data : res_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[g] <= '0;
      else        res_q[g] <= slot_d;
    end
  end

  always_comb begin
    ax_sel  = rd_idx >> 1;
    rd_hit  = rd_idx < IDX_W'(2 * AXES);
    sel_res = '0;
    for (int a = 0; a < AXES; a++) begin
      if (ax_sel == IDX_W'(a)) sel_res = res_q[a];
    end
    padded  = {sel_res, {PAD_W{1'b0}}};
    rd_byte = rd_idx[0] ? padded[BYTE_W-1:0] : padded[2*BYTE_W-1 -: BYTE_W];
  end

endmodule

// File: rtl/spi_conv_target.sv
module spi_conv_target
  import spi_conv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AXES        = 3,
  parameter int RES_W       = 12,
  parameter int AX_W        = $clog2(AXES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              conv_start,
  output logic [AX_W-1:0]   conv_axis,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              reg_wr_en,
  output logic [IDX_W-1:0]  reg_wr_addr,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic [IDX_W-1:0]  reg_rd_addr,
  input  logic [BYTE_W-1:0] reg_rd_data
);

  localparam logic [IDX_W-1:0] LAST_AXIS_BYTE = IDX_W'(2 * AXES - 1);

  // synchronised pins: {cs_n, sclk, sdi}
  logic [2:0] pins_s;
  logic       cs_act, sclk_s, sdi_s;

  spi_in_sync #(.STAGES(SYNC_STAGES), .N(3), .RST_VAL(3'b100)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, sclk, sdi}),
    .dout (pins_s)
  );

  assign cs_act = ~pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  logic              sclk_rise, byte_done;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_byte;

  spi_bit_engine bits_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sclk_s   (sclk_s),
    .sdi_s    (sdi_s),
    .sclk_rise(sclk_rise),
    .bit_cnt  (bit_cnt),
    .byte_done(byte_done),
    .rx_byte  (rx_byte)
  );

  // control state
  phase_t            phase_q, phase_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic              cstart_q, cstart_d;
  logic [AX_W-1:0]   caxis_q, caxis_d;
  logic              wen_q, wen_d;
  logic [IDX_W-1:0]  waddr_q, waddr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              sdo_q, sdo_d;
  logic              oe_q, oe_d;

  logic              st_hit;
  logic [BYTE_W-1:0] st_byte;
  logic [BYTE_W-1:0] tx_live;
  logic [IDX_W-1:0]  cmd_idx;
  logic              cmd_is_conv;

  spi_result_store #(.AXES(AXES), .RES_W(RES_W), .AX_W(AX_W)) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (conv_done),
    .wr_axis(caxis_q),
    .wr_data(conv_data),
    .rd_idx (ptr_q),
    .rd_hit (st_hit),
    .rd_byte(st_byte)
  );

  always_comb begin
    if (st_hit)                   tx_live = st_byte;
    else if (idx_external(ptr_q)) tx_live = reg_rd_data;
    else                          tx_live = '0;
  end

  assign cmd_idx     = rx_byte[IDX_W-1:0];
  assign cmd_is_conv = !cmd_idx[0] && ({1'b0, cmd_idx[IDX_W-1:1]} < IDX_W'(AXES));

  always_comb begin
    phase_d  = phase_q;
    ptr_d    = ptr_q;
    widx_d   = widx_q;
    cstart_d = 1'b0;
    caxis_d  = caxis_q;
    wen_d    = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    hold_d   = hold_q;
    sdo_d    = sdo_q;
    if (!cs_act) begin
      phase_d = PH_CMD;
    end else begin
      if (sclk_rise && (bit_cnt == '0)) hold_d = tx_live;
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            if (rx_byte[BYTE_W-1]) begin
              phase_d = PH_RDATA;
              ptr_d   = cmd_idx;
              if (cmd_is_conv) begin
                cstart_d = 1'b1;
                caxis_d  = AX_W'(cmd_idx[IDX_W-1:1]);
              end
            end else begin
              phase_d = PH_WDATA;
              widx_d  = cmd_idx;
            end
          end
          PH_WDATA: begin
            if (idx_writable(widx_q)) begin
              wen_d   = 1'b1;
              waddr_d = widx_q;
              wdata_d = rx_byte;
            end
            phase_d = PH_HOLD;
          end
          PH_RDATA: ptr_d = idx_step(ptr_q, LAST_AXIS_BYTE);
          default:  phase_d = PH_HOLD;
        endcase
      end
      if (!sclk_s) begin
        sdo_d = (bit_cnt == '0) ? tx_live[BYTE_W-1]
                                : hold_q[CNT_W'(BYTE_W - 1) - bit_cnt];
      end
    end
    oe_d = cs_act && (phase_q == PH_RDATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      ptr_q    <= IDX_TAIL;
      widx_q   <= '0;
      cstart_q <= 1'b0;
      caxis_q  <= '0;
      wen_q    <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      hold_q   <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      ptr_q    <= ptr_d;
      widx_q   <= widx_d;
      cstart_q <= cstart_d;
      caxis_q  <= caxis_d;
      wen_q    <= wen_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
      hold_q   <= hold_d;
      sdo_q    <= sdo_d;
      oe_q     <= oe_d;
    end
  end

  assign sdo         = sdo_q;
  assign sdo_oe      = oe_q;
  assign conv_start  = cstart_q;
  assign conv_axis   = caxis_q;
  assign reg_wr_en   = wen_q;
  assign reg_wr_addr = waddr_q;
  assign reg_wr_data = wdata_q;
  assign reg_rd_addr = ptr_q;

endmodule

// File: rtl/spi_conv_chk.sv
module spi_conv_chk #(
  parameter int AX_W = 2,
  parameter int AXES = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            sclk,
  input logic            sdo,
  input logic            sdo_oe,
  input logic            conv_start,
  input logic [AX_W-1:0] conv_axis,
  input logic            reg_wr_en,
  input logic [6:0]      reg_wr_addr
);

  // R2
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R3
  wr_addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ((reg_wr_addr == 7'h06) || ((reg_wr_addr >= 7'h08) && (reg_wr_addr <= 7'h0D))));

  // R6
  conv_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R6
  conv_axis_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (int'(conv_axis) < AXES));

  // R10
  no_write_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !reg_wr_en);

  // R11
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !sdo_oe);

  // R12
  sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && $past(sclk, 2) && $past(sclk, 3)) |-> $stable(sdo));

endmodule

bind spi_conv_target spi_conv_chk #(.AX_W(AX_W), .AXES(AXES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .conv_start (conv_start),
  .conv_axis  (conv_axis),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_addr(reg_wr_addr)
);

// File: tb/spi_conv_target_tb_top.sv
module spi_conv_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int GAP        = 60;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sclk, sdi;
  logic        sdo, sdo_oe;
  logic        conv_start;
  logic [1:0]  conv_axis;
  logic        conv_done;
  logic [11:0] conv_data;
  logic        reg_wr_en;
  logic [6:0]  reg_wr_addr;
  logic [7:0]  reg_wr_data;
  logic [6:0]  reg_rd_addr;
  logic [7:0]  reg_rd_data;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  int          wr_cnt = 0;
  logic [6:0]  last_wr_addr;
  logic [7:0]  last_wr_data;
  int          conv_cnt = 0;
  logic [1:0]  last_axis;
  int          conv_lat = 20;
  logic [11:0] next_val [3];
  int          pend_cnt = 0;
  logic [1:0]  pend_ax;
  bit          oe_seen;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] reg_model(input logic [6:0] a);
    return {a[3:0], ~a[3:0]};
  endfunction

  assign reg_rd_data = reg_model(reg_rd_addr);

  spi_conv_target dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start), .conv_axis(conv_axis),
    .conv_done(conv_done), .conv_data(conv_data), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  // monitor and converter model
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (rst_n) begin
        if (reg_wr_en) begin
          wr_cnt++;
          last_wr_addr = reg_wr_addr;
          last_wr_data = reg_wr_data;
        end
        if (pend_cnt > 0) begin
          pend_cnt--;
          if (pend_cnt == 0) begin
            conv_done = 1'b1;
            conv_data = next_val[pend_ax];
          end
        end
        if (conv_start) begin
          conv_cnt++;
          last_axis = conv_axis;
          pend_ax   = conv_axis;
          pend_cnt  = conv_lat;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input int n, input logic [7:0] d, output logic [7:0] q);
    q = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = d[i];
      repeat (HALF) @(negedge clk);
      q[i] = sdo;
      if (sdo_oe) oe_seen = 1'b1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] d, output logic [7:0] q);
    spi_bits(8, d, q);
  endtask

  task automatic sel();
    oe_seen = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", sdo_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe", sdo_oe, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 wr_en", reg_wr_en, 0);
  endtask

  task automatic t_write(input logic [6:0] idx, input logic [7:0] d);
    logic [7:0] q;
    int w0 = wr_cnt;
    sel();
    spi_byte({1'b0, idx}, q);
    spi_byte(d, q);
    desel();
    chk("R2 write count", wr_cnt - w0, 1);
    chk("R2 write addr", last_wr_addr, idx);
    chk("R2 write data", last_wr_data, d);
    chk("R11 no oe in write", oe_seen, 0);
  endtask

  task automatic t_write_blocked(input logic [6:0] idx);
    logic [7:0] q;
    int w0 = wr_cnt;
    sel();
    spi_byte({1'b0, idx}, q);
    spi_byte(8'h3C, q);
    desel();
    chk("R3 blocked write", wr_cnt - w0, 0);
  endtask

  task automatic t_reg_stream(input logic [6:0] idx, input int n);
    logic [7:0] q;
    logic [6:0] p = idx;
    logic [7:0] e;
    sel();
    spi_byte({1'b1, idx}, q);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, q);
      e = (p >= 7'h08 && p <= 7'h0E) ? reg_model(p) : 8'h00;
      chk("R4 R8 reg stream byte", q, e);
      if (p == 7'h0E) p = 7'h0D;
      else if (p == 7'h0D) p = 7'h0C;
      else if (p == 7'h0C || p == 7'h7F) p = 7'h7F;
      else p = p + 7'd1;
    end
    chk("R11 oe during read", oe_seen, 1);
    desel();
    chk("R11 oe released", sdo_oe, 0);
  endtask

  task automatic t_unmapped(input logic [6:0] idx);
    logic [7:0] q;
    sel();
    spi_byte({1'b1, idx}, q);
    spi_byte(8'h00, q);
    desel();
    chk("R5 unmapped read", q, 8'h00);
  endtask

  task automatic t_axis_single(input logic [1:0] ax, input logic [11:0] v);
    logic [7:0] qh, ql, q;
    int c0 = conv_cnt;
    next_val[ax] = v;
    sel();
    spi_byte({1'b1, 4'h0, ax, 1'b0}, q);
    repeat (GAP) @(negedge clk);
    spi_byte(8'h00, qh);
    spi_byte(8'h00, ql);
    desel();
    chk("R6 conv count", conv_cnt - c0, 1);
    chk("R6 conv axis", last_axis, ax);
    chk("R7 high byte", qh, v[11:4]);
    chk("R7 low byte", ql, {v[3:0], 4'h0});
  endtask

  task automatic t_axis_stream(input logic [11:0] vx, input logic [11:0] vy, input logic [11:0] vz);
    logic [7:0] q;
    logic [7:0] exp_b [10];
    exp_b[0] = vx[11:4]; exp_b[1] = {vx[3:0], 4'h0};
    exp_b[2] = vy[11:4]; exp_b[3] = {vy[3:0], 4'h0};
    exp_b[4] = vz[11:4]; exp_b[5] = {vz[3:0], 4'h0};
    exp_b[6] = reg_model(7'h0E); exp_b[7] = reg_model(7'h0D);
    exp_b[8] = reg_model(7'h0C); exp_b[9] = 8'h00;
    next_val[0] = vx;
    sel();
    spi_byte(8'h80, q);
    repeat (GAP) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      spi_byte(8'h00, q);
      chk("R8 axis stream byte", q, exp_b[i]);
    end
    desel();
  endtask

  task automatic t_odd_axis(input logic [11:0] vx_low_src);
    logic [7:0] q;
    int c0 = conv_cnt;
    sel();
    spi_byte(8'h81, q);
    spi_byte(8'h00, q);
    desel();
    chk("R6 odd index no conversion", conv_cnt - c0, 0);
    chk("R7 odd index low byte", q, {vx_low_src[3:0], 4'h0});
  endtask

  task automatic t_stale(input logic [11:0] old_v, input logic [11:0] new_v);
    logic [7:0] qh, ql, q;
    next_val[1] = new_v;
    conv_lat = 1000;
    sel();
    spi_byte(8'h82, q);
    spi_byte(8'h00, qh);
    spi_byte(8'h00, ql);
    desel();
    chk("R9 stale high", qh, old_v[11:4]);
    chk("R9 stale low", ql, {old_v[3:0], 4'h0});
    repeat (1100) @(negedge clk);
    conv_lat = 20;
    sel();
    spi_byte(8'h83, q);
    spi_byte(8'h00, q);
    desel();
    chk("R9 late result stored", q, {new_v[3:0], 4'h0});
  endtask

  task automatic t_abort();
    logic [7:0] q;
    int w0 = wr_cnt;
    sel();
    spi_byte(8'h0B, q);
    spi_bits(4, 8'hF0, q);
    desel();
    chk("R10 aborted write", wr_cnt - w0, 0);
    sel();
    spi_byte(8'h8C, q);
    spi_byte(8'h00, q);
    desel();
    chk("R10 fresh command after abort", q, reg_model(7'h0C));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    next_val[0] = '0; next_val[1] = '0; next_val[2] = '0;
    t_reset();
    t_write(7'h0C, 8'h5A);
    t_write(7'h06, 8'hCA);
    t_write(7'h0D, 8'h81);
    t_write_blocked(7'h0E);
    t_write_blocked(7'h03);
    t_write_blocked(7'h20);
    t_reg_stream(7'h0D, 1);
    t_reg_stream(7'h0E, 4);
    t_reg_stream(7'h09, 2);
    t_unmapped(7'h06);
    t_unmapped(7'h07);
    t_unmapped(7'h25);
    t_axis_single(2'd1, 12'h5A3);
    t_axis_single(2'd2, 12'h0F1);
    t_axis_stream(12'hC7E, 12'h5A3, 12'h0F1);
    t_odd_axis(12'hC7E);
    t_stale(12'h5A3, 12'h777);
    t_abort();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule